// File: doc/BRIEF.md
# Console Serial Port Programmed-I/O Front End

This block sits between a processor's programmed-I/O instruction path and a console serial port. Each instruction arrives as a single-cycle strobe. It carries a class, a 4-bit function code and the accumulator value. The four classes are: control pulse (0), skip test (1), input to accumulator (2) and output from accumulator (3). The block keeps the port's control state: receive and transmit interrupt masks, receive and transmit DMA enables, a receive-only mode bit, a one-character receive holding buffer with its error flags, and eight general registers. The eight registers are two receive control words, two transmit control words, two DMA channel addresses and two interrupt vectors.

The response is registered. In the cycle after the instruction, `skip_o` pulses when a skip condition is true or an input/output transfer succeeds. An input transfer also raises `acc_we_o` together with the new accumulator value. A successful character output pulses `tx_valid_o` with the character. An external transmitter and receiver connect through a plain parallel character interface. Serialisation, baud timing and the DMA transfers themselves are done elsewhere.

Top module: `con_pio`

## Requirements
- R1: After reset, and in the cycle after control pulse 017 (master clear), the following hold: both masks are clear, both DMA enables are clear, receive-only mode is on, the receive buffer is empty with all error flags clear, and all eight registers read as zero.
- R2: Control pulses 02, 05 and 015 set the receive mask, the transmit mask and both masks respectively. Control pulses never produce a skip.
- R3: Control pulse 04 clears the receive mask and receive DMA. Pulse 07 clears the transmit mask and transmit DMA. Pulse 016 clears both masks and leaves the DMA enables unchanged. Pulses 03 and 06 set receive DMA and transmit DMA.
- R4: Skip 07 succeeds when a received character is held. Skip 06 succeeds when `tx_ready_i` is high and receive-only mode is off.
- R5: Skip 015, 016 and 017 succeed on the held parity error, overrun and framing error flags. Skip 02 succeeds when the receive interrupt is not asserted, skip 05 when the transmit interrupt is not asserted, and skip 04 when neither is asserted.
- R6: Input 00 returns the accumulator with the held character ORed into its low byte. Input 010 returns the character zero-extended. Both succeed only when a character is held, and a successful read empties the buffer and clears its error flags. With the buffer empty, both fail and leave the state unchanged.
- R7: Output 00 sends accumulator bits 6..0 on `tx_data_o` with a one-cycle `tx_valid_o`. It succeeds only when `tx_ready_i` is high and receive-only mode is off. Control pulse 00 turns receive-only mode on, and pulses 01 and 012 turn it off.
- R8: Input and output functions 04–07 and 014–017 read and write register index {f[3], f[1:0]} and always succeed. Input 011 returns the accumulator ORed with the `DEV_ID` parameter and succeeds.
- R9: `skip_o` and `acc_we_o` are high only in the cycle after a strobed instruction that succeeded, and `acc_we_o` implies `skip_o`. Function codes that are not listed fail and change no state.
- R10: A character arriving on `rx_valid_i` is stored together with its parity and framing flags. If it arrives while the buffer is full and is not read in that same cycle, it overwrites the old character and sets overrun.
- R11: `rx_irq_o` equals receive mask AND buffer full. `tx_irq_o` equals transmit mask AND `tx_ready_i` AND NOT receive-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_valid_i | input | 1 | Instruction strobe |
| io_class_i | input | 2 | 0 control, 1 skip, 2 input, 3 output |
| io_func_i | input | 4 | Function code |
| acc_i | input | DATA_W | Accumulator value |
| skip_o | output | 1 | Success / skip strobe |
| acc_we_o | output | 1 | Accumulator write strobe |
| acc_o | output | DATA_W | New accumulator value |
| tx_ready_i | input | 1 | Transmitter can take a character |
| tx_valid_o | output | 1 | Character send strobe |
| tx_data_o | output | TX_W | Character to send |
| rx_valid_i | input | 1 | New received character |
| rx_data_i | input | CHAR_W | Received character |
| rx_par_err_i | input | 1 | Parity error for the arriving character |
| rx_frm_err_i | input | 1 | Framing error for the arriving character |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_dma_en_o | output | 1 | Receive DMA enable |
| tx_dma_en_o | output | 1 | Transmit DMA enable |

## Verification
The bench uses the defaults DATA_W=16, CHAR_W=8 and TX_W=7. It overrides DEV_ID to 16'o44, so the identifier read can be told apart from a zero or from the accumulator pass-through. Because TX_W is smaller than CHAR_W, accumulator values with bit 7 set show that output 00 truncates the character. A 16-bit accumulator with a nonzero high byte shows that input 00 keeps the high byte and input 010 clears it. Random streams mix character arrivals into instructions on the same cycle, which exercises the overrun and read-while-arriving orderings.

// File: rtl/con_pio_pkg.sv
package con_pio_pkg;
  typedef enum logic [1:0] {
    CLS_CTL  = 2'd0,
    CLS_SKIP = 2'd1,
    CLS_IN   = 2'd2,
    CLS_OUT  = 2'd3
  } io_class_e;

  localparam logic [3:0] F_CHAR    = 4'o00;
  localparam logic [3:0] F_CHAR_CL = 4'o10;
  localparam logic [3:0] F_ID      = 4'o11;
  localparam logic [3:0] F_MCLR    = 4'o17;
endpackage

// File: rtl/con_regfile.sv
module con_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (clr_i)                               regs_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))          regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx_i];
endmodule

// File: rtl/con_rx_buf.sv
module con_rx_buf #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  output logic              full_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              par_o,
  output logic              frm_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0; char_o <= '0; par_o <= 1'b0; frm_o <= 1'b0; ovr_o <= 1'b0;
    end else if (clr_i) begin
      full_o <= 1'b0; char_o <= '0; par_o <= 1'b0; frm_o <= 1'b0; ovr_o <= 1'b0;
    end else if (rx_valid_i) begin
      // arrival beats a same-cycle read; overrun only if old char was not taken
      full_o <= 1'b1;
      char_o <= rx_data_i;
      par_o  <= par_err_i;
      frm_o  <= frm_err_i;
      ovr_o  <= full_o && !take_i;
    end else if (take_i) begin
      full_o <= 1'b0; par_o <= 1'b0; frm_o <= 1'b0; ovr_o <= 1'b0;
    end
  end

  // R10
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && full_o && !take_i && !clr_i) |=> (ovr_o && full_o));

  // R6
  take_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !rx_valid_i) |=> (!full_o && !ovr_o));
endmodule

// File: rtl/con_ctl.sv
module con_ctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_i,
  input  logic [3:0] func_i,
  output logic       rx_mask_o,
  output logic       tx_mask_o,
  output logic       rx_dma_o,
  output logic       tx_dma_o,
  output logic       rx_only_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_mask_o <= 1'b0; tx_mask_o <= 1'b0;
      rx_dma_o  <= 1'b0; tx_dma_o  <= 1'b0;
      rx_only_o <= 1'b1;
    end else if (pulse_i) begin
      unique case (func_i)
        4'o00: rx_only_o <= 1'b1;
        4'o01: rx_only_o <= 1'b0;
        4'o02: rx_mask_o <= 1'b1;
        4'o03: rx_dma_o  <= 1'b1;
        4'o04: begin rx_mask_o <= 1'b0; rx_dma_o <= 1'b0; end
        4'o05: tx_mask_o <= 1'b1;
        4'o06: tx_dma_o  <= 1'b1;
        4'o07: begin tx_mask_o <= 1'b0; tx_dma_o <= 1'b0; end
        4'o12: rx_only_o <= 1'b0;
        4'o15: begin rx_mask_o <= 1'b1; tx_mask_o <= 1'b1; end
        4'o16: begin rx_mask_o <= 1'b0; tx_mask_o <= 1'b0; end
        4'o17: begin
          rx_mask_o <= 1'b0; tx_mask_o <= 1'b0;
          rx_dma_o  <= 1'b0; tx_dma_o  <= 1'b0;
          rx_only_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R1
  mclr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && func_i == 4'o17) |=>
      (!rx_mask_o && !tx_mask_o && !rx_dma_o && !tx_dma_o && rx_only_o));

  // R3
  both_mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && func_i == 4'o16) |=>
      (!rx_mask_o && !tx_mask_o && $stable(rx_dma_o) && $stable(tx_dma_o)));
endmodule

// File: rtl/con_pio.sv
module con_pio
  import con_pio_pkg::*;
#(
  parameter int              DATA_W = 16,
  parameter int              CHAR_W = 8,
  parameter int              TX_W   = 7,
  parameter logic [DATA_W-1:0] DEV_ID = DATA_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_valid_i,
  input  logic [1:0]        io_class_i,
  input  logic [3:0]        io_func_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              skip_o,
  output logic              acc_we_o,
  output logic [DATA_W-1:0] acc_o,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [TX_W-1:0]   tx_data_o,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  output logic              rx_irq_o,
  output logic              tx_irq_o,
  output logic              rx_dma_en_o,
  output logic              tx_dma_en_o
);
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int PAD_W    = DATA_W - CHAR_W;

  io_class_e cls;
  assign cls = io_class_e'(io_class_i);

  logic              rx_mask, tx_mask, rx_only;
  logic              rx_full, rx_par, rx_frm, rx_ovr;
  logic [CHAR_W-1:0] rx_char;
  logic [DATA_W-1:0] reg_rdata;
  logic [IDX_W-1:0]  reg_idx;
  logic              is_reg, tx_can, mclr;
  logic              ok_d, we_d, tx_go, reg_we, take;
  logic [DATA_W-1:0] acc_d;

  // register functions are 04-07 and 014-017
  assign is_reg  = io_func_i[2];
  assign reg_idx = {io_func_i[3], io_func_i[1:0]};
  assign tx_can  = tx_ready_i && !rx_only;
  assign mclr    = io_valid_i && cls == CLS_CTL && io_func_i == F_MCLR;

  assign rx_irq_o = rx_mask && rx_full;
  assign tx_irq_o = tx_mask && tx_can;

  con_ctl u_ctl (
    .clk_i, .rst_ni,
    .pulse_i   (io_valid_i && cls == CLS_CTL),
    .func_i    (io_func_i),
    .rx_mask_o (rx_mask),
    .tx_mask_o (tx_mask),
    .rx_dma_o  (rx_dma_en_o),
    .tx_dma_o  (tx_dma_en_o),
    .rx_only_o (rx_only)
  );

  con_rx_buf #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i, .rst_ni,
    .clr_i      (mclr),
    .take_i     (take),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .par_err_i  (rx_par_err_i),
    .frm_err_i  (rx_frm_err_i),
    .full_o     (rx_full),
    .char_o     (rx_char),
    .par_o      (rx_par),
    .frm_o      (rx_frm),
    .ovr_o      (rx_ovr)
  );

  con_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .clr_i   (mclr),
    .we_i    (reg_we),
    .idx_i   (reg_idx),
    .wdata_i (acc_i),
    .rdata_o (reg_rdata)
  );

  always_comb begin
    ok_d = 1'b0; we_d = 1'b0; acc_d = '0;
    tx_go = 1'b0; reg_we = 1'b0; take = 1'b0;
    if (io_valid_i) begin
      unique case (cls)
        CLS_SKIP: begin
          unique case (io_func_i)
            4'o02:   ok_d = !rx_irq_o;
            4'o04:   ok_d = !rx_irq_o && !tx_irq_o;
            4'o05:   ok_d = !tx_irq_o;
            4'o06:   ok_d = tx_can;
            4'o07:   ok_d = rx_full;
            4'o15:   ok_d = rx_par;
            4'o16:   ok_d = rx_ovr;
            4'o17:   ok_d = rx_frm;
            default: ok_d = 1'b0;
          endcase
        end
        CLS_IN: begin
          if ((io_func_i == F_CHAR || io_func_i == F_CHAR_CL) && rx_full) begin
            ok_d = 1'b1; we_d = 1'b1; take = 1'b1;
            acc_d = {{PAD_W{1'b0}}, rx_char} | (io_func_i[3] ? '0 : acc_i);
          end else if (io_func_i == F_ID) begin
            ok_d = 1'b1; we_d = 1'b1; acc_d = acc_i | DEV_ID;
          end else if (is_reg) begin
            ok_d = 1'b1; we_d = 1'b1; acc_d = reg_rdata;
          end
        end
        CLS_OUT: begin
          if (io_func_i == F_CHAR) begin
            ok_d = tx_can; tx_go = tx_can;
          end else if (is_reg) begin
            ok_d = 1'b1; reg_we = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_o <= 1'b0; acc_we_o <= 1'b0; acc_o <= '0;
      tx_valid_o <= 1'b0; tx_data_o <= '0;
    end else begin
      skip_o     <= ok_d;
      acc_we_o   <= we_d;
      acc_o      <= acc_d;
      tx_valid_o <= tx_go;
      if (tx_go) tx_data_o <= acc_i[TX_W-1:0];
    end
  end

  // R9
  we_implies_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> skip_o);

  // R9
  skip_needs_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> ($past(io_valid_i) && $past(io_class_i) != CLS_CTL));

  // R7
  tx_from_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(io_valid_i && io_class_i == CLS_OUT &&
                         io_func_i == F_CHAR && tx_ready_i));

  // R11
  irq_zero_after_mclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> (!rx_irq_o && !tx_irq_o));
endmodule

// File: tb/con_pio_bench.sv
`timescale 1ns/1ps
module con_pio_bench;
  localparam logic [15:0] ID = 16'o44;

  logic        clk = 0, rst_ni = 0;
  logic        io_valid = 0;
  logic [1:0]  io_class = 0;
  logic [3:0]  io_func = 0;
  logic [15:0] acc = 0;
  logic        skip, acc_we, tx_valid, rx_irq, tx_irq, rx_dma, tx_dma;
  logic [15:0] acc_out;
  logic [6:0]  tx_data;
  logic        tx_ready = 0, rx_valid = 0, rx_pe = 0, rx_fe = 0;
  logic [7:0]  rx_data = 0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_rxm, m_txm, m_rxd, m_txd, m_rxonly, m_full, m_par, m_frm, m_ovr;
  logic [7:0]  m_char;
  logic [15:0] m_regs [8];

  always #10 clk = ~clk;

  con_pio #(.DEV_ID(ID)) u_con_pio (
    .clk_i(clk), .rst_ni, .io_valid_i(io_valid), .io_class_i(io_class),
    .io_func_i(io_func), .acc_i(acc), .skip_o(skip), .acc_we_o(acc_we),
    .acc_o(acc_out), .tx_ready_i(tx_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_par_err_i(rx_pe), .rx_frm_err_i(rx_fe), .rx_irq_o(rx_irq),
    .tx_irq_o(tx_irq), .rx_dma_en_o(rx_dma), .tx_dma_en_o(tx_dma)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rxm = 0; m_txm = 0; m_rxd = 0; m_txd = 0; m_rxonly = 1;
    m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0; m_char = 0;
    for (int i = 0; i < 8; i++) m_regs[i] = 0;
  endtask

  task automatic check_static(string tag);
    chk(tag, "rx_irq", rx_irq, m_rxm & m_full);
    chk(tag, "tx_irq", tx_irq, m_txm & tx_ready & ~m_rxonly);
    chk(tag, "rx_dma", rx_dma, m_rxd);
    chk(tag, "tx_dma", tx_dma, m_txd);
  endtask

  task automatic do_op(string tag, logic iv, logic [1:0] c, logic [3:0] f,
                       logic [15:0] a, logic txr, logic rv, logic [7:0] rd,
                       logic pe, logic fe);
    bit e_skip, e_we, e_txv, take, mc, is_reg, txc, irx, itx;
    logic [15:0] e_acc;
    logic [6:0]  e_txd;
    logic [2:0]  idx;
    @(negedge clk);
    io_valid = iv; io_class = c; io_func = f; acc = a; tx_ready = txr;
    rx_valid = rv; rx_data = rd; rx_pe = pe; rx_fe = fe;
    e_skip = 0; e_we = 0; e_acc = 0; e_txv = 0; e_txd = 0; take = 0;
    is_reg = f[2]; idx = {f[3], f[1:0]};
    txc = txr & ~m_rxonly;
    irx = m_rxm & m_full; itx = m_txm & txc;
    mc = iv && c == 0 && f == 4'o17;
    if (iv) begin
      if (c == 1) begin
        case (f)
          4'o02: e_skip = !irx;
          4'o04: e_skip = !irx && !itx;
          4'o05: e_skip = !itx;
          4'o06: e_skip = txc;
          4'o07: e_skip = m_full;
          4'o15: e_skip = m_par;
          4'o16: e_skip = m_ovr;
          4'o17: e_skip = m_frm;
          default: e_skip = 0;
        endcase
      end else if (c == 2) begin
        if ((f == 0 || f == 8) && m_full) begin
          e_skip = 1; e_we = 1; take = 1;
          e_acc = (f == 8) ? {8'h00, m_char} : {a[15:8], a[7:0] | m_char};
        end else if (f == 9) begin
          e_skip = 1; e_we = 1; e_acc = a | ID;
        end else if (is_reg) begin
          e_skip = 1; e_we = 1; e_acc = m_regs[idx];
        end
      end else if (c == 3) begin
        if (f == 0) begin
          e_skip = txc; e_txv = txc; e_txd = a[6:0];
        end else if (is_reg) begin
          e_skip = 1; m_regs[idx] = a;
        end
      end else begin
        case (f)
          4'o00: m_rxonly = 1;
          4'o01: m_rxonly = 0;
          4'o02: m_rxm = 1;
          4'o03: m_rxd = 1;
          4'o04: begin m_rxm = 0; m_rxd = 0; end
          4'o05: m_txm = 1;
          4'o06: m_txd = 1;
          4'o07: begin m_txm = 0; m_txd = 0; end
          4'o12: m_rxonly = 0;
          4'o15: begin m_rxm = 1; m_txm = 1; end
          4'o16: begin m_rxm = 0; m_txm = 0; end
          default: ;
        endcase
      end
    end
    if (mc) model_reset();
    else if (rv) begin
      m_ovr = m_full && !take; m_full = 1; m_char = rd; m_par = pe; m_frm = fe;
    end else if (take) begin
      m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0;
    end
    @(negedge clk);
    chk(tag, "skip", skip, e_skip);
    chk(tag, "acc_we", acc_we, e_we);
    if (e_we) chk(tag, "acc", acc_out, e_acc);
    chk(tag, "tx_valid", tx_valid, e_txv);
    if (e_txv) chk(tag, "tx_data", tx_data, e_txd);
    check_static(tag);
    io_valid = 0; rx_valid = 0;
  endtask

  // instruction only
  task automatic ins(string tag, logic [1:0] c, logic [3:0] f, logic [15:0] a, logic txr);
    do_op(tag, 1, c, f, a, txr, 0, 8'h00, 0, 0);
  endtask

  // character arrival only
  task automatic arrive(string tag, logic [7:0] d, logic pe, logic fe);
    do_op(tag, 0, 0, 0, 16'h0, tx_ready, 1, d, pe, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1F2E);
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check_static("R1");
    chk("R1", "skip_idle", skip, 0);
    ins("R1", 2, 4'o04, 16'hFFFF, 0);        // reg read returns zero
    ins("R4", 1, 4'o07, 0, 0);               // nothing received
    ins("R7", 3, 4'o00, 16'h0041, 1);        // rx-only after reset: fails
    // R2 / R3 masks and DMA
    ins("R2", 0, 4'o02, 0, 0);
    ins("R3", 0, 4'o03, 0, 0);
    ins("R3", 0, 4'o06, 0, 0);
    ins("R2", 0, 4'o05, 0, 1);
    ins("R3", 0, 4'o16, 0, 1);               // masks clear, DMA kept
    ins("R2", 0, 4'o15, 0, 1);
    ins("R3", 0, 4'o07, 0, 1);
    // R10 arrival, R11 interrupt
    arrive("R10", 8'h5A, 0, 0);
    ins("R4", 1, 4'o07, 0, 0);
    ins("R5", 1, 4'o02, 0, 0);               // rx interrupting: no skip
    ins("R6", 2, 4'o00, 16'hAB21, 0);        // AB7B
    ins("R6", 2, 4'o10, 16'hFFFF, 0);        // empty: fails
    arrive("R10", 8'h81, 1, 0);
    arrive("R10", 8'hC3, 0, 1);              // overrun
    ins("R5", 1, 4'o16, 0, 0);
    ins("R5", 1, 4'o17, 0, 0);
    ins("R5", 1, 4'o15, 0, 0);
    ins("R6", 2, 4'o10, 16'hFFFF, 0);        // 00C3
    ins("R5", 1, 4'o16, 0, 0);               // cleared by read
    // R7 transmit
    ins("R7", 0, 4'o01, 0, 1);
    ins("R4", 1, 4'o06, 0, 1);
    ins("R7", 3, 4'o00, 16'h12FF, 1);        // sends 7F
    ins("R7", 3, 4'o00, 16'h0041, 0);        // not ready: fails
    ins("R7", 0, 4'o00, 0, 1);
    ins("R7", 3, 4'o00, 16'h0041, 1);        // rx-only: fails
    ins("R7", 0, 4'o12, 0, 1);
    // R8 registers and id
    for (int i = 0; i < 8; i++)
      ins("R8", 3, {i[2], 1'b1, i[1:0]}, 16'h1000 + 16'(i * 3), 0);
    for (int i = 0; i < 8; i++)
      ins("R8", 2, {i[2], 1'b1, i[1:0]}, 16'h0, 0);
    ins("R8", 2, 4'o11, 16'h0100, 0);
    ins("R9", 2, 4'o03, 16'h0, 0);           // unlisted input fails
    ins("R9", 3, 4'o02, 16'h0, 0);
    ins("R11", 0, 4'o05, 0, 1);
    ins("R5", 1, 4'o05, 0, 1);
    ins("R5", 1, 4'o04, 0, 0);
    ins("R1", 0, 4'o17, 0, 1);
    ins("R1", 2, 4'o05, 16'h0, 0);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] c; logic [3:0] f;
      c = 2'($urandom % 4); f = 4'($urandom % 16);
      if (c == 0 && f == 4'o17 && ($urandom % 8) != 0) f = 4'o02;
      do_op("R9", ($urandom % 5) != 0, c, f, 16'($urandom), 1'($urandom % 2),
            ($urandom % 3) == 0, 8'($urandom), 1'($urandom % 4 == 0),
            1'($urandom % 4 == 0));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule